// File: doc/BRIEF.md
# Status Register Write Protection Unit

This block holds the status register of a serial non-volatile memory and decides, for every request, whether a write to the array or to the status register may proceed. It keeps a busy indication, a write enable latch, a two-bit block-protect level and a pin-enable bit, and it samples an active-low write-protect pin. The serial front end drives its command strobes: set or clear of the enable latch, a status write with a data byte, an array write with its address, and the start and completion of the internal write cycle. The block returns the status byte for reading, a protected flag for the address currently presented, and a flag saying whether a status write would be accepted now.

Hardware protection is active when the pin is low and the pin-enable bit is 1. The block-protect level selects no protection, the top quarter, the top half, or the whole array. The pin-enable and block-protect bits stand for non-volatile cells: only the power-on reset clears them, while the soft reset clears the latch and the state machine.

A five-state machine orders the work. IDLE accepts latch commands and requests; an accepted status request moves to STS_PEND, an accepted array request to ARR_PEND. STS_PEND returns to IDLE (cancel) when hardware protection becomes active, else moves to STS_BUSY on cycle start. ARR_PEND moves to ARR_BUSY on cycle start. Both busy states return to IDLE on cycle completion, clearing the latch; STS_BUSY also commits the pending bits then.

Top module: `sr_wp_unit`

## Requirements
- R1: When no internal cycle runs, the status byte is bit 7 pin-enable, bits 6..4 zero, bits 3..2 block-protect level, bit 1 write enable latch, bit 0 zero.
- R2: From the edge that starts an internal cycle until the edge that completes it, the status byte reads 8'hFF.
- R3: With a 14-bit address, level 2'b00 protects no address, 2'b01 protects 0x3000..0x3FFF, 2'b10 protects 0x2000..0x3FFF and 2'b11 protects every address; addr_prot reports this for arr_wr_addr.
- R4: In IDLE, wel_set sets the latch and wel_clr clears it (clear wins when both), whatever the pin and pin-enable values.
- R5: With the latch clear, status and array write requests are ignored and a following cycle start does not make the block busy.
- R6: An array write request to a protected address is ignored even with the latch set; one to an unprotected address is accepted.
- R7: With the pin low and pin-enable 1, status write requests are ignored and sts_wr_ok is 0, while array writes to unprotected addresses are still accepted.
- R8: Hardware protection becoming active while a status write is pending cancels it; once its cycle has started, the pin has no effect and the write commits.
- R9: Completing any internal cycle clears the latch; a status write changes only bits 7, 3 and 2 (from data bits 7, 3 and 2), at completion.
- R10: During an internal cycle, latch commands and write requests are ignored.
- R11: The soft reset clears the latch and returns to IDLE while pin-enable and block-protect keep their values; the power-on reset clears them all.
- R12: With pin-enable 0 the pin level is ignored: sts_wr_ok is 1 in IDLE with the latch set, and status writes are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears all state |
| rst_n | input | 1 | Soft reset, active low, synchronous; keeps non-volatile bits |
| wp_n | input | 1 | Write-protect pin, active low |
| wel_set | input | 1 | Set write enable latch |
| wel_clr | input | 1 | Clear write enable latch |
| sts_wr_req | input | 1 | Status write request |
| sts_wr_data | input | 8 | Status write data byte |
| arr_wr_req | input | 1 | Array write request |
| arr_wr_addr | input | ADDR_W | Array address for request and protection lookup |
| cyc_start | input | 1 | Internal write cycle starts |
| cyc_done | input | 1 | Internal write cycle completes |
| status_byte | output | 8 | Status byte for reading |
| addr_prot | output | 1 | arr_wr_addr lies in a protected block |
| sts_wr_ok | output | 1 | A status write would be accepted now |

## Verification
The bench builds the block with its default 14-bit address, so the quarter and half boundaries fall at 0x3000 and 0x2000 and the addresses on either side of each can be presented directly. A behavioural model tracks the state, latch and non-volatile bits and is compared every cycle, while directed sequences walk through every protection level, the cancel-before-start and pin-after-start cases of a pending status write, writes with the pin-enable clear, and both resets.

// File: rtl/wp_status_pkg.sv
package wp_status_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STS_PEND,
        ST_ARR_PEND,
        ST_STS_BUSY,
        ST_ARR_BUSY
    } cyc_state_e;

    typedef struct packed {
        logic       pin_en;
        logic [1:0] level;
    } nv_bits_t;

    localparam int STS_W       = 8;
    localparam int POS_PIN_EN  = 7;
    localparam int POS_LVL_HI  = 3;
    localparam int POS_LVL_LO  = 2;
    localparam int POS_WEL     = 1;

endpackage

// File: rtl/wp_range_decode.sv
module wp_range_decode #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [1:0]        level,
    input  logic [ADDR_W-1:0] addr,
    output logic              prot
);
    localparam int TOP = ADDR_W - 1;

    always_comb begin
        unique case (level)
            2'b00:   prot = 1'b0;
            2'b01:   prot = addr[TOP] & addr[TOP-1];
            2'b10:   prot = addr[TOP];
            default: prot = 1'b1;
        endcase
    end

    // R3
    lvl_none_chk: assert property (@(posedge clk) disable iff (!por_n)
        (level == 2'b00) |-> !prot);

    // R3
    lvl_full_chk: assert property (@(posedge clk) disable iff (!por_n)
        (level == 2'b11) |-> prot);

endmodule

// File: rtl/wp_nv_bits.sv
module wp_nv_bits
    import wp_status_pkg::*;
(
    input  logic     clk,
    input  logic     por_n,
    input  logic     commit,
    input  nv_bits_t commit_val,
    output nv_bits_t bits_q
);
    always_ff @(posedge clk) begin
        if (!por_n)
            bits_q <= '0;
        else if (commit)
            bits_q <= commit_val;
    end

    // R11
    nv_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        !commit |=> $stable(bits_q));

endmodule

// File: rtl/wp_cycle_fsm.sv
module wp_cycle_fsm
    import wp_status_pkg::*;
(
    input  logic     clk,
    input  logic     por_n,
    input  logic     rst_n,
    input  logic     wel_set,
    input  logic     wel_clr,
    input  logic     sts_req,
    input  nv_bits_t sts_val,
    input  logic     arr_req,
    input  logic     arr_prot,
    input  logic     cyc_start,
    input  logic     cyc_done,
    input  logic     hw_prot,
    output logic     wel,
    output logic     busy,
    output logic     idle,
    output logic     commit,
    output nv_bits_t commit_val
);
    cyc_state_e state_q, state_d;
    nv_bits_t   pend_q;
    logic       wel_q;
    logic       any_rst;

    assign any_rst = !rst_n || !por_n;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sts_req && wel_q && !hw_prot)
                    state_d = ST_STS_PEND;
                else if (arr_req && wel_q && !arr_prot)
                    state_d = ST_ARR_PEND;
            end
            ST_STS_PEND: begin
                if (hw_prot)
                    state_d = ST_IDLE;
                else if (cyc_start)
                    state_d = ST_STS_BUSY;
            end
            ST_ARR_PEND: begin
                if (cyc_start)
                    state_d = ST_ARR_BUSY;
            end
            ST_STS_BUSY, ST_ARR_BUSY: begin
                if (cyc_done)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (any_rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (any_rst) begin
            wel_q  <= 1'b0;
            pend_q <= '0;
        end else begin
            if (busy && cyc_done)
                wel_q <= 1'b0;
            else if (idle && wel_clr)
                wel_q <= 1'b0;
            else if (idle && wel_set)
                wel_q <= 1'b1;
            if (idle && state_d == ST_STS_PEND)
                pend_q <= sts_val;
        end
    end

    always_comb begin
        idle       = (state_q == ST_IDLE);
        busy       = (state_q == ST_STS_BUSY) || (state_q == ST_ARR_BUSY);
        wel        = wel_q;
        commit     = !any_rst && (state_q == ST_STS_BUSY) && cyc_done;
        commit_val = pend_q;
    end

    // R9
    wel_auto_clr_chk: assert property (@(posedge clk) disable iff (any_rst)
        (busy && cyc_done) |=> !wel);

    // R5
    no_wel_idle_chk: assert property (@(posedge clk) disable iff (any_rst)
        (idle && !wel_q) |=> idle);

    // R10
    busy_wel_hold_chk: assert property (@(posedge clk) disable iff (any_rst)
        (busy && !cyc_done) |=> (busy && $stable(wel_q)));

    // R7
    hw_block_chk: assert property (@(posedge clk) disable iff (any_rst)
        (idle && sts_req && hw_prot) |=> (state_q != ST_STS_PEND));

endmodule

// File: rtl/sr_wp_unit.sv
module sr_wp_unit
    import wp_status_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              wp_n,
    input  logic              wel_set,
    input  logic              wel_clr,
    input  logic              sts_wr_req,
    input  logic [7:0]        sts_wr_data,
    input  logic              arr_wr_req,
    input  logic [ADDR_W-1:0] arr_wr_addr,
    input  logic              cyc_start,
    input  logic              cyc_done,
    output logic [7:0]        status_byte,
    output logic              addr_prot,
    output logic              sts_wr_ok
);
    nv_bits_t nv_q, sts_val, commit_val;
    logic     hw_prot, wel, busy, idle, commit;
    logic     unused_data_bits;

    assign unused_data_bits = ^{sts_wr_data[6:4], sts_wr_data[1:0]};
    assign sts_val = '{pin_en: sts_wr_data[POS_PIN_EN],
                       level:  sts_wr_data[POS_LVL_HI:POS_LVL_LO]};
    assign hw_prot = !wp_n && nv_q.pin_en;

    wp_range_decode #(.ADDR_W(ADDR_W)) u_range (
        .clk   (clk),
        .por_n (por_n),
        .level (nv_q.level),
        .addr  (arr_wr_addr),
        .prot  (addr_prot)
    );

    wp_nv_bits u_nv (
        .clk        (clk),
        .por_n      (por_n),
        .commit     (commit),
        .commit_val (commit_val),
        .bits_q     (nv_q)
    );

    wp_cycle_fsm u_fsm (
        .clk        (clk),
        .por_n      (por_n),
        .rst_n      (rst_n),
        .wel_set    (wel_set),
        .wel_clr    (wel_clr),
        .sts_req    (sts_wr_req),
        .sts_val    (sts_val),
        .arr_req    (arr_wr_req),
        .arr_prot   (addr_prot),
        .cyc_start  (cyc_start),
        .cyc_done   (cyc_done),
        .hw_prot    (hw_prot),
        .wel        (wel),
        .busy       (busy),
        .idle       (idle),
        .commit     (commit),
        .commit_val (commit_val)
    );

    always_comb begin
        if (busy)
            status_byte = {STS_W{1'b1}};
        else
            status_byte = {nv_q.pin_en, 3'b000, nv_q.level, wel, 1'b0};
        sts_wr_ok = idle && wel && !hw_prot;
    end

    // R11
    soft_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> (status_byte[1:0] == 2'b00));

endmodule

// File: tb/sr_wp_unit_tb_top.sv
module sr_wp_unit_tb_top;
    localparam int AW = 14;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          por_n = 1'b0, rst_n = 1'b0, wp_n = 1'b1;
    logic          wel_set = 1'b0, wel_clr = 1'b0;
    logic          sts_wr_req = 1'b0, arr_wr_req = 1'b0;
    logic [7:0]    sts_wr_data = 8'h00;
    logic [AW-1:0] arr_wr_addr = '0;
    logic          cyc_start = 1'b0, cyc_done = 1'b0;
    logic [7:0]    status_byte;
    logic          addr_prot, sts_wr_ok;

    int n_chk = 0, n_fail = 0, n_cyc = 0;

    // model: mode 0 idle, 1 status pending, 2 array pending, 3 status busy, 4 array busy
    int   m_mode = 0;
    bit   m_wel = 0, m_pen = 0;
    bit   [1:0] m_lvl = 0, p_lvl = 0;
    bit   p_pen = 0;

    always #10 clk = ~clk;

    sr_wp_unit #(.ADDR_W(AW)) dut_i (.*);

    function automatic bit exp_prot(bit [1:0] lvl, int a);
        case (lvl)
            2'd0: return 1'b0;
            2'd1: return a >= (DEPTH * 3) / 4;
            2'd2: return a >= DEPTH / 2;
            default: return 1'b1;
        endcase
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit hwp;
        hwp = !wp_n && m_pen;
        if (!por_n) begin
            m_mode = 0; m_wel = 0; m_pen = 0; m_lvl = 0;
        end else if (!rst_n) begin
            m_mode = 0; m_wel = 0;
        end else begin
            case (m_mode)
                0: begin
                    if (sts_wr_req && m_wel && !hwp) begin
                        m_mode = 1; p_pen = sts_wr_data[7]; p_lvl = sts_wr_data[3:2];
                    end else if (arr_wr_req && m_wel && !exp_prot(m_lvl, int'(arr_wr_addr)))
                        m_mode = 2;
                    if (wel_clr) m_wel = 0;
                    else if (wel_set) m_wel = 1;
                end
                1: if (hwp) m_mode = 0; else if (cyc_start) m_mode = 3;
                2: if (cyc_start) m_mode = 4;
                default: if (cyc_done) begin
                    if (m_mode == 3) begin m_pen = p_pen; m_lvl = p_lvl; end
                    m_mode = 0; m_wel = 0;
                end
            endcase
        end
        #5;
        if (por_n) begin
            logic [7:0] es;
            es = (m_mode >= 3) ? 8'hFF : {m_pen, 3'b000, m_lvl, m_wel, 1'b0};
            chk("model R1 R2 status", status_byte, es);
            chk("model R3 prot", {7'd0, addr_prot}, {7'd0, exp_prot(m_lvl, int'(arr_wr_addr))});
            chk("model R7 R12 ok", {7'd0, sts_wr_ok}, {7'd0, (m_mode == 0) && m_wel && !hwp});
        end
    end

    task automatic tick(); @(negedge clk); endtask
    task automatic p_set();   tick(); wel_set = 1; tick(); wel_set = 0; endtask
    task automatic p_clr();   tick(); wel_clr = 1; tick(); wel_clr = 0; endtask
    task automatic p_start(); tick(); cyc_start = 1; tick(); cyc_start = 0; endtask
    task automatic p_done();  tick(); cyc_done = 1; tick(); cyc_done = 0; endtask
    task automatic p_sts(logic [7:0] d);
        tick(); sts_wr_req = 1; sts_wr_data = d; tick(); sts_wr_req = 0;
    endtask
    task automatic p_arr(int a);
        tick(); arr_wr_req = 1; arr_wr_addr = AW'(a); tick(); arr_wr_req = 0;
    endtask
    task automatic wr_status(logic [7:0] d);
        p_set(); p_sts(d); p_start(); p_done();
    endtask
    task automatic chk_prot(string tag, int a, bit e);
        tick(); arr_wr_addr = AW'(a); tick();
        chk(tag, {7'd0, addr_prot}, {7'd0, e});
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc == 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        repeat (3) tick();
        por_n = 1; rst_n = 1; tick();
        chk("R1 R11 reset status", status_byte, 8'h00);
        chk("R4 reset ok flag", {7'd0, sts_wr_ok}, 8'h00);
        // R5: no latch, array request then start stays idle
        p_arr(16'h0100); p_start();
        chk("R5 no latch no cycle", status_byte, 8'h00);
        // R4
        p_set();
        chk("R4 latch set", status_byte, 8'h02);
        // R2 R10 R9
        p_sts(8'hFF);
        chk("R1 pending not busy", status_byte, 8'h02);
        p_start();
        chk("R2 busy all ones", status_byte, 8'hFF);
        p_sts(8'h00); p_clr(); p_set();
        chk("R10 still busy", status_byte, 8'hFF);
        p_done();
        chk("R9 R10 commit bits 7,3,2", status_byte, 8'h8C);
        chk_prot("R3 full level addr 0", 0, 1'b1);
        // R3 levels
        wr_status(8'h08);
        chk("R9 level 2", status_byte, 8'h08);
        chk_prot("R3 half below", 16'h1FFF, 1'b0);
        chk_prot("R3 half edge", 16'h2000, 1'b1);
        wr_status(8'h00);
        chk_prot("R3 none top", 16'h3FFF, 1'b0);
        wr_status(8'h04);
        chk_prot("R3 quarter below", 16'h2FFF, 1'b0);
        chk_prot("R3 quarter edge", 16'h3000, 1'b1);
        chk_prot("R3 quarter top", 16'h3FFF, 1'b1);
        // R6
        p_set(); p_arr(16'h3100); p_start();
        chk("R6 protected ignored", status_byte, 8'h06);
        p_arr(16'h0010); p_start();
        chk("R6 unprotected busy", status_byte, 8'hFF);
        p_done();
        chk("R6 R9 done", status_byte, 8'h04);
        // R7
        wr_status(8'h84);
        chk("R9 pin enable set", status_byte, 8'h84);
        tick(); wp_n = 0;
        p_set();
        chk("R7 ok flag low", {7'd0, sts_wr_ok}, 8'h00);
        p_sts(8'h00); p_start();
        chk("R7 status write blocked", status_byte, 8'h86);
        p_arr(16'h0010); p_start();
        chk("R7 array still writable", status_byte, 8'hFF);
        p_done();
        // R4 clear with pin low
        p_set(); p_clr();
        chk("R4 clear with pin low", status_byte, 8'h84);
        // R8 cancel before start
        tick(); wp_n = 1;
        p_set(); p_sts(8'h88);
        wp_n = 0; tick();
        p_start();
        chk("R8 pending cancelled", status_byte, 8'h86);
        tick(); wp_n = 1;
        p_sts(8'h88); p_start();
        wp_n = 0; tick();
        p_done();
        chk("R8 pin after start ignored", status_byte, 8'h88);
        // R12
        tick(); wp_n = 1;
        wr_status(8'h00);
        tick(); wp_n = 0;
        p_set();
        chk("R12 ok flag with enable clear", {7'd0, sts_wr_ok}, 8'h01);
        p_sts(8'h0C); p_start(); p_done();
        chk("R12 write accepted pin low", status_byte, 8'h0C);
        // R11
        p_set();
        tick(); rst_n = 0; tick(); rst_n = 1; tick();
        chk("R11 soft reset keeps level", status_byte, 8'h0C);
        tick(); por_n = 0; tick(); por_n = 1; tick();
        chk("R11 power-on clears", status_byte, 8'h00);
        repeat (2) tick();
        finish_run();
    end
endmodule